// File: doc/BRIEF.md
# Pipelined Median-of-Nine Filter Core

This block takes a set of nine 8-bit pixel values, such as a 3x3 neighbourhood, and returns their median. The values pass through a fixed network of compare-exchange elements. Each element puts the smaller of its two lanes on the lower lane and the larger on the upper lane. The network is the odd-even transposition type, so stage s compares lane pairs whose lower index has the parity of s. Nine such stages leave the nine lanes fully ordered, and the middle lane carries the median.

A register follows every stage. The block therefore takes a fresh set on every clock and delivers one median per clock after a fixed latency equal to the number of stages. A one-bit valid flag moves through a shift register of the same length, so each result leaves the block alongside the flag of the set it came from. Window formation, line storage and image borders are left to the surrounding pipeline.

Top module: `med9_sort_pipe`

## Requirements
- R1: When out_valid is high, out_median equals the fifth smallest of the nine values of the corresponding input set. That is the value with more than four of the nine at or below it and fewer than five strictly below it.
- R2: The latency is exactly NUM_PIX (9) clock edges. A set sampled at one rising edge appears on the outputs just after the ninth rising edge counted from that one. out_valid stays low for the first 8 edges after reset is released.
- R3: A new input set is accepted on every clock. A back-to-back stream of sets gives a back-to-back stream of medians in the same order.
- R4: out_valid equals in_valid delayed by exactly 9 clock edges. A cycle with in_valid low produces a cycle with out_valid low at the matching output slot.
- R5: Repeated values in a set still give the correct median. It does not matter which of two equal values fills which lane.
- R6: An active-high synchronous reset clears every valid bit. After an edge with rst high, no set that was in flight, and no set presented while rst was high, raises out_valid.
- R7: The result does not depend on which input lane (bits [8k+7:8k], k = 0..8) carries which value. Ascending and descending arrangements of the same values give the same median.
- R8: The full range of the value field is handled. Sets made of 0 and 255 give 0 or 255 according to which value has at least five copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the valid pipeline |
| in_valid | input | 1 | Marks in_pix as a set to be filtered |
| in_pix | input | 72 | Nine 8-bit values; value k sits in bits [8k+7:8k] |
| out_valid | output | 1 | Marks out_median as the median of a set |
| out_median | output | 8 | Median of the set that entered 9 cycles earlier |

## Verification
The bound checker assumes that in_pix holds known values whenever in_valid is high. It also assumes that reset is held for at least one rising edge before any valid set arrives, because the checker's own reference pipeline clears only on that reset. The bench respects both conditions. It drives every input on the falling edge and holds rst high from time zero. While valid is low it fills in_pix with a fixed filler pattern, so no unknown value ever enters the network.

// File: rtl/med9_pkg.sv
package med9_pkg;

   // Lane pairing of an odd-even transposition network:
   // stage s compares lanes (i, i+1) whenever i has the parity of s.
   function automatic bit is_low_lane(int stage, int lane, int n);
      int par;
      par = stage % 2;
      return (lane >= par) && (((lane - par) % 2) == 0) && (lane + 1 < n);
   endfunction

   function automatic bit is_high_lane(int stage, int lane, int n);
      return (lane >= 1) && is_low_lane(stage, lane - 1, n);
   endfunction

   function automatic int mid_lane(int n);
      return (n - 1) / 2;
   endfunction

endpackage

// File: rtl/med_cmpx.sv
module med_cmpx #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi
);
   logic swap;
   assign swap = (a > b);
   assign lo   = swap ? b : a;
   assign hi   = swap ? a : b;
endmodule

// File: rtl/med_sort_stage.sv
module med_sort_stage
   import med9_pkg::*;
#(
   parameter int W     = 8,
   parameter int N     = 9,
   parameter int STAGE = 0
) (
   input  logic           clk,
   input  logic [N*W-1:0] lanes_i,
   output logic [N*W-1:0] lanes_o
);
   logic [N*W-1:0] nxt;

   for (genvar i = 0; i < N; i++) begin : g_lane
      if (is_low_lane(STAGE, i, N)) begin : g_cx
         med_cmpx #(.W(W)) u_cx (
            .a  (lanes_i[i*W +: W]),
            .b  (lanes_i[(i+1)*W +: W]),
            .lo (nxt[i*W +: W]),
            .hi (nxt[(i+1)*W +: W])
         );
      end else if (!is_high_lane(STAGE, i, N)) begin : g_pass
         assign nxt[i*W +: W] = lanes_i[i*W +: W];
      end
   end

   always_ff @(posedge clk) begin
      lanes_o <= nxt;
   end
endmodule

// File: rtl/med_valid_pipe.sv
module med_valid_pipe #(
   parameter int DEPTH = 9
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [DEPTH-1:0] sr;

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (rst) sr <= '0;
         else     sr <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk) begin
         if (rst) sr <= '0;
         else     sr <= {sr[DEPTH-2:0], d};
      end
   end

   assign q = sr[DEPTH-1];
endmodule

// File: rtl/med9_sort_pipe.sv
module med9_sort_pipe
   import med9_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter int NUM_PIX = 9
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic [NUM_PIX*PIX_W-1:0] in_pix,
   output logic                     out_valid,
   output logic [PIX_W-1:0]         out_median
);
   localparam int LATENCY = NUM_PIX;
   localparam int MID     = mid_lane(NUM_PIX);
   localparam int BUS_W   = NUM_PIX * PIX_W;

   if (NUM_PIX < 3 || (NUM_PIX % 2) == 0) begin : g_bad_count
      $error("med9_sort_pipe: NUM_PIX must be odd and at least 3");
   end
   if (PIX_W < 1) begin : g_bad_width
      $error("med9_sort_pipe: PIX_W must be positive");
   end

   logic [BUS_W-1:0] stage_bus [LATENCY+1];
   logic             unused_lanes;

   assign stage_bus[0] = in_pix;

   for (genvar s = 0; s < LATENCY; s++) begin : g_stage
      med_sort_stage #(
         .W     (PIX_W),
         .N     (NUM_PIX),
         .STAGE (s)
      ) u_stage (
         .clk     (clk),
         .lanes_i (stage_bus[s]),
         .lanes_o (stage_bus[s+1])
      );
   end

   med_valid_pipe #(.DEPTH(LATENCY)) u_vpipe (
      .clk (clk),
      .rst (rst),
      .d   (in_valid),
      .q   (out_valid)
   );

   assign out_median   = stage_bus[LATENCY][MID*PIX_W +: PIX_W];
   assign unused_lanes = ^stage_bus[LATENCY];
endmodule

// File: rtl/med9_sort_pipe_chk.sv
module med9_sort_pipe_chk #(
   parameter int PIX_W   = 8,
   parameter int NUM_PIX = 9
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic [NUM_PIX*PIX_W-1:0] in_pix,
   input logic                     out_valid,
   input logic [PIX_W-1:0]         out_median
);
   localparam int LAT  = NUM_PIX;
   localparam int RANK = (NUM_PIX + 1) / 2;

   logic [PIX_W-1:0] rank_val;
   logic             ref_v [LAT];
   logic [PIX_W-1:0] ref_m [LAT];
   int unsigned      since_rst;

   always_comb begin
      rank_val = '0;
      for (int i = 0; i < NUM_PIX; i++) begin
         int n_le;
         int n_lt;
         n_le = 0;
         n_lt = 0;
         for (int j = 0; j < NUM_PIX; j++) begin
            if (in_pix[j*PIX_W +: PIX_W] <= in_pix[i*PIX_W +: PIX_W]) n_le++;
            if (in_pix[j*PIX_W +: PIX_W] <  in_pix[i*PIX_W +: PIX_W]) n_lt++;
         end
         if (n_le >= RANK && n_lt < RANK) rank_val = in_pix[i*PIX_W +: PIX_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst <= 0;
         for (int k = 0; k < LAT; k++) ref_v[k] <= 1'b0;
      end else begin
         if (since_rst < LAT) since_rst <= since_rst + 1;
         ref_v[0] <= in_valid;
         for (int k = 1; k < LAT; k++) ref_v[k] <= ref_v[k-1];
      end
      ref_m[0] <= rank_val;
      for (int k = 1; k < LAT; k++) ref_m[k] <= ref_m[k-1];
   end

   // R6
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid);

   // R2
   warmup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (since_rst < LAT) |-> !out_valid);

   // R4
   valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid == ref_v[LAT-1]);

   // R1
   median_rank_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_median == ref_m[LAT-1]));
endmodule

bind med9_sort_pipe med9_sort_pipe_chk #(
   .PIX_W   (PIX_W),
   .NUM_PIX (NUM_PIX)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_pix     (in_pix),
   .out_valid  (out_valid),
   .out_median (out_median)
);

// File: tb/med9_sort_pipe_test.sv
`timescale 1ns/1ps
module med9_sort_pipe_test;
   localparam int W   = 8;
   localparam int N   = 9;
   localparam int LAT = 9;
   localparam int NV  = 10;

   // {expected median, nine values}
   localparam logic [79:0] VEC [NV] = '{
      {8'd5,   8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd9},
      {8'd5,   8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1},
      {8'h7F,  8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F},
      {8'd0,   8'd0, 8'd0, 8'd0, 8'd0, 8'd255, 8'd0, 8'd0, 8'd0, 8'd0},
      {8'd255, 8'd0, 8'd0, 8'd0, 8'd0, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
      {8'd0,   8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd255, 8'd255, 8'd255, 8'd255},
      {8'd128, 8'd255, 8'd0, 8'd128, 8'd127, 8'd129, 8'd1, 8'd254, 8'd2, 8'd253},
      {8'd20,  8'd10, 8'd20, 8'd20, 8'd20, 8'd30, 8'd5, 8'd5, 8'd40, 8'd20},
      {8'd125, 8'd200, 8'd100, 8'd150, 8'd50, 8'd250, 8'd0, 8'd175, 8'd125, 8'd75},
      {8'd4,   8'd3, 8'd3, 8'd4, 8'd4, 8'd4, 8'd2, 8'd2, 8'd9, 8'd9}
   };

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           in_valid = 1'b0;
   logic [N*W-1:0] in_pix = {N{8'hA5}};
   logic           out_valid;
   logic [W-1:0]   out_median;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   med9_sort_pipe uut (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_pix     (in_pix),
      .out_valid  (out_valid),
      .out_median (out_median)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit slot_valid(input int c, input bit gappy);
      return (c >= 0) && (c < NV) && (!gappy || (c % 2 == 0));
   endfunction

   // R1 R3 R4 R5 R7 R8: walk the table, one set per clock
   task automatic run_stream(input bit gappy);
      for (int c = 0; c <= NV + LAT; c++) begin
         int  k;
         bit  ev;
         @(negedge clk);
         k  = c - LAT;
         ev = slot_valid(k, gappy);
         check(out_valid == ev, gappy ? "R4 valid with gaps" : "R2/R3 valid timing",
               int'(out_valid), int'(ev));
         if (ev)
            check(out_median == VEC[k][79:72], "R1/R5/R7/R8 median",
                  int'(out_median), int'(VEC[k][79:72]));
         if (c < NV) begin
            in_valid = slot_valid(c, gappy);
            in_pix   = VEC[c][71:0];
         end else begin
            in_valid = 1'b0;
            in_pix   = {N{8'hA5}};
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_pix   = {N{8'hA5}};
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R6 reset state
      check(out_valid == 1'b0, "R6 reset state", int'(out_valid), 0);
      idle(LAT + 2);

      run_stream(1'b0);
      idle(LAT + 2);
      run_stream(1'b1);
      idle(LAT + 2);

      // R6: sets in flight, and a set presented during reset, are dropped
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_pix   = VEC[i][71:0];
      end
      @(negedge clk);
      rst      = 1'b1;
      in_valid = 1'b1;
      @(negedge clk);
      rst      = 1'b0;
      in_valid = 1'b0;
      for (int i = 0; i < LAT + 2; i++) begin
         check(out_valid == 1'b0, "R6 flush after reset", int'(out_valid), 0);
         @(negedge clk);
      end

      // R2: a single set after reset emerges exactly LAT edges later
      in_valid = 1'b1;
      in_pix   = VEC[6][71:0];
      for (int i = 1; i <= LAT; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_pix   = {N{8'hA5}};
         check(out_valid == (i == LAT), "R2 single set latency",
               int'(out_valid), int'(i == LAT));
      end
      check(out_median == 8'd128, "R2 single set value", int'(out_median), 128);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule